// File: doc/BRIEF.md
# Advanced Load Address Table

This block tracks loads that were hoisted above earlier stores. When such a load completes, it writes an entry into a small fully associative table. The entry holds the load's destination register, its memory address and the value it returned. Every store that executes afterwards presents its address. Each valid entry whose address falls in the same aligned 8-byte word is dropped, and the destination registers of those entries come out as a one-cycle bit mask. The register file uses that mask to set the registers' not-a-thing flags.

Before consuming a speculative value, code issues a check for a register. The check answers with a hit, meaning the entry is still valid, and the recorded value. A hit also releases the entry. A miss tells the caller to run recovery code.

The check path is a valid/ready stream with a registered response. A check is taken when `chk_valid` and `chk_ready` are both high. Its answer appears on `rsp_*` in the next cycle and stays unchanged until `rsp_ready` is high. While an answer is held back, `chk_ready` is low. The load port also has a valid/ready pair, but `ld_ready` is tied high, so the table takes an allocation in every cycle. The store port and the poison mask are plain pins.

Top module: `alat_top`

## Requirements
- R1: After reset no entry is valid, `poison_mask` is 0, `rsp_valid` is 0, and `ld_ready` and `chk_ready` are 1.
- R2: A check taken in cycle k answers in cycle k+1 with `rsp_valid`=1. A register with a valid entry gives `rsp_hit`=1 and the value recorded by its allocation.
- R3: A check for a register with no valid entry answers `rsp_hit`=0 and `rsp_data`=0.
- R4: A check that hits releases the entry, so a second check for that register misses.
- R5: A store invalidates every valid entry whose address equals the store address in bits [ADDR_W-1:3]; the low three bits are ignored. In the next cycle `poison_mask` has bit n set for destination register n, and for one cycle only. A store to a different 8-byte word has no effect.
- R6: A store matching several entries reports all of their registers in one `poison_mask` word.
- R7: An allocation to a register that already has a valid entry overwrites that entry. The old address no longer matches, and at most one entry exists per register.
- R8: An allocation takes the lowest-numbered free entry. When all entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each replacement. The displaced register then misses.
- R9: When a store and an allocation hit the same word in one cycle, the allocation is treated as older. The new entry survives and its register is not poisoned, while other matching entries are poisoned.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the response holds steady and `chk_ready` is 0.
- R11: `ld_ready` is always 1.
- R12: A check sees the table as it was at the start of its cycle. A check and a matching store in the same cycle give a hit with the old value, and the store still poisons the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Completed advanced load to record |
| ld_ready | output | 1 | Always 1 |
| ld_reg | input | REG_W | Destination register of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_data | input | DATA_W | Value returned by the load |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request |
| chk_ready | output | 1 | Check can be taken |
| chk_reg | input | REG_W | Register being checked |
| rsp_valid | output | 1 | Check answer present |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_hit | output | 1 | Entry was valid |
| rsp_data | output | DATA_W | Recorded value on a hit, 0 on a miss |
| poison_mask | output | NUM_REGS | One-cycle mask of registers to poison |

## Verification
The hardest conditions to reach from the ports are those where several operations meet on one entry in one cycle. Examples are an allocation replacing a victim while a store hits the same word, or a check freeing an entry that the allocation is also taking. These only arise once the table is full and the round-robin pointer has moved. The stimulus first fills all sixteen entries and forces replacements. It then runs a long random phase with a handful of registers and only eight address words, with all three ports active at once and random response back-pressure. A behavioural table model in the bench is compared against the design on every cycle.

// File: rtl/alat_pkg.sv
package alat_pkg;
  // Where the slot chosen for an allocation came from.
  typedef enum logic [1:0] {
    SLOT_NONE     = 2'd0,
    SLOT_SAME_REG = 2'd1,
    SLOT_FREE     = 2'd2,
    SLOT_VICTIM   = 2'd3
  } slot_src_e;
endpackage

// File: rtl/alat_match.sv
module alat_match #(
  parameter int N      = 16,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  parameter int LSB    = 3
) (
  input  logic [N-1:0]             ent_valid,
  input  logic [N-1:0][REG_W-1:0]  ent_reg,
  input  logic [N-1:0][ADDR_W-1:0] ent_addr,
  input  logic [REG_W-1:0]         ld_reg,
  input  logic [REG_W-1:0]         chk_reg,
  input  logic                     st_valid,
  input  logic [ADDR_W-1:0]        st_addr,
  output logic [N-1:0]             ld_hit,
  output logic [N-1:0]             chk_hit,
  output logic [N-1:0]             st_hit
);
  // One comparator set per entry: two register tags and one word address.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign ld_hit[i]  = ent_valid[i] && (ent_reg[i] == ld_reg);
    assign chk_hit[i] = ent_valid[i] && (ent_reg[i] == chk_reg);
    assign st_hit[i]  = st_valid && ent_valid[i] &&
                        (ent_addr[i][ADDR_W-1:LSB] == st_addr[ADDR_W-1:LSB]);
  end
endmodule

// File: rtl/alat_slot_pick.sv
module alat_slot_pick
  import alat_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             ld_valid,
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     ld_hit,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [N-1:0]     slot_onehot,
  output slot_src_e        slot_src
);
  logic [N-1:0] free_vec;
  logic [N-1:0] lowest_free;

  assign free_vec    = ~ent_valid;
  assign lowest_free = free_vec & (~free_vec + N'(1));

  // Priority: same register, then lowest free entry, then round-robin victim.
  always_comb begin
    slot_onehot = '0;
    slot_src    = SLOT_NONE;
    if (ld_valid) begin
      if (|ld_hit) begin
        slot_onehot = ld_hit;
        slot_src    = SLOT_SAME_REG;
      end else if (|free_vec) begin
        slot_onehot = lowest_free;
        slot_src    = SLOT_FREE;
      end else begin
        slot_onehot = N'(1) << rr_ptr;
        slot_src    = SLOT_VICTIM;
      end
    end
  end
endmodule

// File: rtl/alat_poison_gen.sv
module alat_poison_gen #(
  parameter int N      = 16,
  parameter int REG_W  = 5,
  parameter int NREGS  = 32
) (
  input  logic [N-1:0]            kill,
  input  logic [N-1:0][REG_W-1:0] ent_reg,
  output logic [NREGS-1:0]        mask
);
  // Decode each killed entry's register and merge into one mask.
  always_comb begin
    mask = '0;
    for (int i = 0; i < N; i++) begin
      if (kill[i]) mask = mask | (NREGS'(1) << ent_reg[i]);
    end
  end
endmodule

// File: rtl/alat_top.sv
module alat_top
  import alat_pkg::*;
#(
  parameter int N_ENTRIES  = 16,
  parameter int NUM_REGS   = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int GRAN_BYTES = 8,
  localparam int REG_W     = $clog2(NUM_REGS),
  localparam int IDX_W     = $clog2(N_ENTRIES),
  localparam int GRAN_LSB  = $clog2(GRAN_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [REG_W-1:0]    ld_reg,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic                chk_valid,
  output logic                chk_ready,
  input  logic [REG_W-1:0]    chk_reg,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [NUM_REGS-1:0] poison_mask
);
  localparam int N = N_ENTRIES;

  logic [N-1:0]             ent_valid;
  logic [N-1:0][REG_W-1:0]  ent_reg;
  logic [N-1:0][ADDR_W-1:0] ent_addr;
  logic [N-1:0][DATA_W-1:0] ent_data;
  logic [IDX_W-1:0]         rr_ptr;

  logic [N-1:0]        ld_hit, chk_hit, st_hit;
  logic [N-1:0]        alloc_vec, kill_vec, chk_free_vec, valid_nxt;
  logic [NUM_REGS-1:0] mask_nxt;
  logic [DATA_W-1:0]   chk_value;
  logic                chk_fire;
  slot_src_e           slot_src;

  assign ld_ready  = 1'b1;
  assign chk_ready = !rsp_valid || rsp_ready;
  assign chk_fire  = chk_valid && chk_ready;

  alat_match #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .LSB(GRAN_LSB)) u_match (
    .ent_valid (ent_valid),
    .ent_reg   (ent_reg),
    .ent_addr  (ent_addr),
    .ld_reg    (ld_reg),
    .chk_reg   (chk_reg),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .ld_hit    (ld_hit),
    .chk_hit   (chk_hit),
    .st_hit    (st_hit)
  );

  alat_slot_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .ld_valid    (ld_valid),
    .ent_valid   (ent_valid),
    .ld_hit      (ld_hit),
    .rr_ptr      (rr_ptr),
    .slot_onehot (alloc_vec),
    .slot_src    (slot_src)
  );

  // The allocation counts as older than a same-cycle store, so its slot is spared.
  assign kill_vec     = st_hit & ~alloc_vec;
  assign chk_free_vec = chk_fire ? (chk_hit & ~alloc_vec) : '0;
  assign valid_nxt    = (ent_valid & ~kill_vec & ~chk_free_vec) | alloc_vec;

  alat_poison_gen #(.N(N), .REG_W(REG_W), .NREGS(NUM_REGS)) u_poison (
    .kill    (kill_vec),
    .ent_reg (ent_reg),
    .mask    (mask_nxt)
  );

  // AND-OR read mux; at most one entry can match a register.
  always_comb begin
    chk_value = '0;
    for (int i = 0; i < N; i++) begin
      if (chk_hit[i]) chk_value = chk_value | ent_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid   <= '0;
      rr_ptr      <= '0;
      poison_mask <= '0;
    end else begin
      ent_valid   <= valid_nxt;
      poison_mask <= mask_nxt;
      if (slot_src == SLOT_VICTIM) begin
        rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (alloc_vec[i]) begin
        ent_reg[i]  <= ld_reg;
        ent_addr[i] <= ld_addr;
        ent_data[i] <= ld_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else if (chk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= |chk_hit;
      rsp_data  <= chk_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));

  // R10
  chk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ready) |-> rsp_valid);

  // R7
  one_entry_per_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_hit));

  // R9
  alloc_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ((ent_valid & $past(alloc_vec)) == $past(alloc_vec)));

  // R4
  check_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && |chk_hit) |=> ((ent_valid & $past(chk_free_vec)) == '0));

  // R5
  poison_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st_valid) |-> (poison_mask == '0));

  // R11
  ld_always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready);
endmodule

// File: tb/tb_alat_top.sv
module tb_alat_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, ld_ready;
  logic [4:0]  ld_reg;
  logic [31:0] ld_addr;
  logic [63:0] ld_data;
  logic        st_valid;
  logic [31:0] st_addr;
  logic        chk_valid, chk_ready;
  logic [4:0]  chk_reg;
  logic        rsp_valid, rsp_ready, rsp_hit;
  logic [63:0] rsp_data;
  logic [31:0] poison_mask;

  always #2 clk = ~clk;

  alat_top dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_reg(ld_reg),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .poison_mask(poison_mask)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference table model
  bit          m_v [N];
  int          m_r [N];
  logic [31:0] m_a [N];
  logic [63:0] m_d [N];
  int          m_rr;
  logic [31:0] e_poison;
  bit          e_rv, e_rh;
  logic [63:0] e_rd;

  task automatic expect64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit fire;
    int ci, li, slot;
    logic [31:0] pm;
    logic [63:0] cdata;
    fire = chk_valid && (!e_rv || rsp_ready);
    ci = -1; li = -1; slot = -1; pm = '0; cdata = '0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_r[i] == int'(chk_reg)) ci = i;
      if (m_v[i] && m_r[i] == int'(ld_reg)) li = i;
    end
    if (ci >= 0) cdata = m_d[ci];
    if (ld_valid) begin
      if (li >= 0) slot = li;
      else begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
          slot = m_rr;
          m_rr = (m_rr + 1) % N;
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      if (st_valid && m_v[i] && (m_a[i] >> 3) == (st_addr >> 3) && i != slot) begin
        pm[m_r[i]] = 1'b1;
        m_v[i] = 0;
      end
    end
    if (fire && ci >= 0 && ci != slot) m_v[ci] = 0;
    if (slot >= 0) begin
      m_v[slot] = 1; m_r[slot] = int'(ld_reg); m_a[slot] = ld_addr; m_d[slot] = ld_data;
    end
    if (fire) begin
      e_rv = 1; e_rh = (ci >= 0); e_rd = cdata;
    end else if (rsp_ready) e_rv = 0;
    e_poison = pm;
  endtask

  // One clock: check ready, advance the model, sample the registered outputs.
  task automatic cyc();
    #1;
    expect64("R10 chk_ready", 64'(chk_ready), 64'(!e_rv || rsp_ready));
    model_step();
    @(negedge clk);
    expect64("R5 poison_mask", 64'(poison_mask), 64'(e_poison));
    expect64("R2 rsp_valid", 64'(rsp_valid), 64'(e_rv));
    if (e_rv) begin
      expect64("R2 rsp_hit", 64'(rsp_hit), 64'(e_rh));
      expect64("R2 rsp_data", rsp_data, e_rd);
    end
  endtask

  task automatic idle();
    ld_valid = 0; st_valid = 0; chk_valid = 0; rsp_ready = 1;
    ld_reg = '0; ld_addr = '0; ld_data = '0; st_addr = '0; chk_reg = '0;
  endtask

  task automatic do_ld(int r, logic [31:0] a, logic [63:0] d);
    ld_valid = 1; ld_reg = 5'(r); ld_addr = a; ld_data = d;
  endtask

  task automatic do_st(logic [31:0] a);
    st_valid = 1; st_addr = a;
  endtask

  task automatic do_ck(int r);
    chk_valid = 1; chk_reg = 5'(r);
  endtask

  task automatic check_reg(string tag, int r, bit hit, logic [63:0] d);
    idle(); do_ck(r); cyc();
    expect64({tag, " hit"}, 64'(rsp_hit), 64'(hit));
    expect64({tag, " data"}, rsp_data, d);
    idle();
  endtask

  task automatic drain();
    for (int r = 0; r < 32; r++) begin
      idle(); do_ck(r); cyc();
    end
    idle(); cyc();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r[i] = 0; m_a[i] = '0; m_d[i] = '0; end
    m_rr = 0; e_poison = '0; e_rv = 0; e_rh = 0; e_rd = '0;
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect64("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    expect64("R1 poison", 64'(poison_mask), 64'd0);
    expect64("R1 chk_ready", 64'(chk_ready), 64'd1);
    expect64("R11 ld_ready", 64'(ld_ready), 64'd1);
    rst_n = 1;
    idle(); cyc();
    check_reg("R3 empty miss", 5, 0, 64'd0);

    // R2 / R4
    idle(); do_ld(3, 32'h1000, 64'hA1A1_0000_0000_0003); cyc();
    check_reg("R2 hit", 3, 1, 64'hA1A1_0000_0000_0003);
    check_reg("R4 freed", 3, 0, 64'd0);

    // R5 byte-in-word match and different word
    idle(); do_ld(7, 32'h2008, 64'h77); cyc();
    idle(); do_st(32'h200F); cyc();
    expect64("R5 poison r7", 64'(poison_mask), 64'h80);
    idle(); cyc();
    expect64("R5 one-cycle pulse", 64'(poison_mask), 64'd0);
    check_reg("R5 invalidated", 7, 0, 64'd0);
    idle(); do_ld(8, 32'h2008, 64'h88); cyc();
    idle(); do_st(32'h2010); cyc();
    expect64("R5 other word", 64'(poison_mask), 64'd0);
    check_reg("R5 untouched", 8, 1, 64'h88);

    // R6 multiple matches
    idle(); do_ld(1, 32'h3000, 64'h11); cyc();
    idle(); do_ld(2, 32'h3000, 64'h22); cyc();
    idle(); do_st(32'h3004); cyc();
    expect64("R6 two regs", 64'(poison_mask), 64'h6);

    // R7 overwrite
    idle(); do_ld(4, 32'h4000, 64'h40); cyc();
    idle(); do_ld(4, 32'h5000, 64'h50); cyc();
    idle(); do_st(32'h4000); cyc();
    expect64("R7 old addr", 64'(poison_mask), 64'd0);
    check_reg("R7 new value", 4, 1, 64'h50);

    // R8 fill then replace
    drain();
    for (int r = 10; r < 26; r++) begin
      idle(); do_ld(r, 32'h8000 + 32'(r * 64), 64'(r)); cyc();
    end
    idle(); do_ld(26, 32'h9000, 64'h26); cyc();
    check_reg("R8 victim slot0", 10, 0, 64'd0);
    check_reg("R8 new entry", 26, 1, 64'h26);
    check_reg("R8 neighbour kept", 11, 1, 64'd11);

    // R9 allocation and store to the same word
    drain();
    idle(); do_ld(29, 32'h6000, 64'h29); cyc();
    idle(); do_ld(30, 32'h6000, 64'h30); do_st(32'h6003); cyc();
    expect64("R9 only old entry", 64'(poison_mask), 64'h2000_0000);
    check_reg("R9 survivor", 30, 1, 64'h30);

    // R12 check and store in the same cycle
    idle(); do_ld(12, 32'h7000, 64'hC12); cyc();
    idle(); do_ck(12); do_st(32'h7000); cyc();
    expect64("R12 hit", 64'(rsp_hit), 64'd1);
    expect64("R12 data", rsp_data, 64'hC12);
    expect64("R12 poison", 64'(poison_mask), 64'h1000);

    // R10 back-pressure
    idle(); do_ld(13, 32'hA000, 64'hD13); cyc();
    idle(); rsp_ready = 0; do_ck(13); cyc();
    expect64("R10 rsp hit", 64'(rsp_hit), 64'd1);
    for (int k = 0; k < 3; k++) begin
      idle(); rsp_ready = 0; do_ck(13);
      #1 expect64("R10 stalled", 64'(chk_ready), 64'd0);
      cyc();
      expect64("R10 held data", rsp_data, 64'hD13);
    end
    idle(); do_ck(13); cyc();
    expect64("R10 then R4 miss", 64'(rsp_hit), 64'd0);

    // Random phase: model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      idle();
      rsp_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 1) == 1)
        do_ld($urandom_range(0, 19), 32'h100 + 32'($urandom_range(0, 7) * 8 + $urandom_range(0, 7)),
              {$urandom(), $urandom()});
      if ($urandom_range(0, 9) < 3)
        do_st(32'h100 + 32'($urandom_range(0, 7) * 8 + $urandom_range(0, 7)));
      if ($urandom_range(0, 1) == 1) do_ck($urandom_range(0, 19));
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule